// File: doc/BRIEF.md
# SPI Host Packet Exchange Sequencer

This block acts as the SPI master for one complete half-duplex packet exchange with a peripheral. After a `start` pulse it clocks the outbound packet out of a byte source and throws away whatever comes back on the data-in line. It then sends four zero bytes, the response window, and scans the replies for the first non-zero byte. That byte is the peripheral's packet header. The sequencer then keeps sending zeros until it has received the whole reply. The reply length is read from the header as soon as the header arrives.

Reply bytes are presented one at a time on `rx_valid`/`rx_data`, starting with the header. Only the header is checked. The payload is passed through untouched. The exchange ends with a one-cycle `done` pulse, and `err` tells success from failure. A system built around this block uses the byte strobe to feed a packet parser, and uses `done`/`err` to decide whether to retry.

Top module: `spi_xchg_seq`

## Requirements
- R1: After reset the block is idle: `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `rx_valid`=0.
- R2: In the first phase the block sends exactly `tx_len` bytes. Each byte is taken from `tx_byte`, and one `tx_next` pulse marks each byte taken. Bytes are shifted MSB first in SPI mode 0: `mosi` is valid while `sclk` is low, data is sampled on the rising edge, and each `sclk` half period lasts `HALF_DIV` clock cycles. Bytes read back during this phase never appear on `rx_valid`.
- R3: After the outbound packet, the block sends exactly four 0x00 bytes (the response window).
- R4: Within the window, zero bytes that come before the first non-zero byte are dropped. The first non-zero byte is the header. The header and every later reply byte are presented on `rx_data` with a one-cycle `rx_valid`.
- R5: A header is valid when all 8 bits together have even parity (bit 0 is the parity bit) and its length field, bits 7:1, is a non-zero multiple of 4. An invalid first non-zero byte ends the exchange right after that byte, with `err`=1, and the byte is not forwarded.
- R6: If all four window bytes are zero, the exchange ends after the fourth one with `err`=1.
- R7: After the window the block sends 0x00 bytes until the number of reply bytes received, header included, equals the header length field. It then ends with `err`=0. If the window alone already completes the reply, no extra bytes are sent.
- R8: `cs_n` stays low from the first bit to the last bit of the exchange and goes high in the cycle that `done` pulses. `sclk` is low whenever `cs_n` is high.
- R9: A `start` pulse that arrives while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (accepted only when idle) |
| tx_len | input | 7 | Outbound packet length in bytes (multiple of 4, at least 4) |
| tx_byte | input | 8 | Current outbound byte from the source |
| tx_next | output | 1 | Pulse: `tx_byte` was taken, the source advances |
| sclk | output | 1 | SPI serial clock (idle low) |
| mosi | output | 1 | SPI data to the peripheral |
| miso | input | 1 | SPI data from the peripheral |
| cs_n | output | 1 | Active-low chip select |
| rx_valid | output | 1 | Pulse: `rx_data` holds a reply byte |
| rx_data | output | 8 | Reply byte |
| done | output | 1 | Pulse: exchange finished |
| err | output | 1 | Result of the last exchange (1 = failed) |
| busy | output | 1 | Exchange in progress |

## Verification
A phase counter that slips by one byte shows up at the end of that same exchange as a wrong total number of clocked bytes. It also produces either a missing zero byte in the mosi log or a reply stream that begins with a phase-one byte. A wrong header decision, whether a parity or length mistake or a header taken at the wrong window slot, changes `err` and the clocked byte count at the `done` pulse. Wrong length bookkeeping makes the reply stream one byte short or long. All of these faults show up within one exchange, and the sweep over header position and length makes every window slot carry the header at least once.

// File: rtl/spi_xchg_seq.sv
module spi_xchg_seq #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] tx_len,
  input  logic [7:0] tx_byte,
  output logic       tx_next,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       cs_n,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       done,
  output logic       err,
  output logic       busy
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(HALF_DIV - 1);
  localparam logic [1:0] PH_OUT = 2'd1, PH_WIN = 2'd2, PH_TAIL = 2'd3;

  logic [1:0]    ph;
  logic [7:0]    txsh, rxsh;
  logic [2:0]    bitc;
  logic [DW-1:0] divc;
  logic [6:0]    tot, sent, need, got;
  logic [1:0]    wcnt;
  logic          found;

  wire tick    = busy && (divc == DLAST);
  wire nz      = |rxsh;
  wire hdr_ok  = ~^rxsh && (rxsh[2:1] == 2'b00) && (|rxsh[7:3]);
  wire new_hdr = (ph == PH_WIN) && !found && nz;
  wire bad     = new_hdr && !hdr_ok;
  wire fwd     = ((ph == PH_WIN) && found) || (new_hdr && hdr_ok) || (ph == PH_TAIL);
  wire [6:0] got_n  = new_hdr ? 7'd1 : got + 7'd1;
  wire [6:0] need_n = new_hdr ? rxsh[7:1] : need;
  wire found_n = found || new_hdr;
  wire win_end = (ph == PH_WIN) && (wcnt == 2'd3);
  wire fin_ok  = (win_end && found_n && !bad && got_n == need_n) ||
                 ((ph == PH_TAIL) && got_n == need);
  wire fin_err = bad || (win_end && !found_n);

  assign cs_n = !busy;
  assign mosi = busy && txsh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= PH_OUT; txsh <= '0; rxsh <= '0; bitc <= '0; divc <= '0;
      sclk <= 1'b0; tot <= '0; sent <= '0; need <= '0; got <= '0; wcnt <= '0;
      found <= 1'b0; tx_next <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      rx_valid <= 1'b0;
      tx_next <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; ph <= PH_OUT; tot <= tx_len; sent <= 7'd1;
          txsh <= tx_byte; tx_next <= 1'b1; bitc <= '0; divc <= '0;
          sclk <= 1'b0; found <= 1'b0; wcnt <= '0; got <= '0;
        end
      end else begin
        divc <= tick ? '0 : divc + 1'b1;
        if (tick && !sclk) begin
          sclk <= 1'b1;
          rxsh <= {rxsh[6:0], miso};
        end else if (tick && sclk) begin
          sclk <= 1'b0;
          if (bitc != 3'd7) begin
            bitc <= bitc + 3'd1;
            txsh <= {txsh[6:0], 1'b0};
          end else begin
            bitc <= '0;
            if (ph == PH_OUT) begin
              if (sent == tot) begin
                ph <= PH_WIN;
                txsh <= '0;
              end else begin
                sent <= sent + 7'd1;
                txsh <= tx_byte;
                tx_next <= 1'b1;
              end
            end else begin
              txsh <= '0;
              if (fwd) begin
                rx_valid <= 1'b1;
                rx_data <= rxsh;
              end
              got <= got_n;
              need <= need_n;
              found <= found_n;
              wcnt <= wcnt + 2'd1;
              if (win_end) ph <= PH_TAIL;
              if (fin_ok || fin_err) begin
                busy <= 1'b0;
                done <= 1'b1;
                err <= fin_err;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_xchg_seq_chk.sv
module spi_xchg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cs_n,
  input logic sclk,
  input logic done,
  input logic busy,
  input logic tx_next,
  input logic rx_valid
);
  a_r8_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_txnext_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    tx_next |-> !cs_n);
  a_r4_rx_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(!cs_n));
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind spi_xchg_seq spi_xchg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sclk(sclk),
  .done(done), .busy(busy), .tx_next(tx_next), .rx_valid(rx_valid)
);

// File: tb/spi_xchg_seq_tb_top.sv
module spi_xchg_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] tx_len = 7'd4;
  logic [7:0] tx_byte;
  logic tx_next, sclk, mosi, cs_n, rx_valid, done, err, busy;
  logic miso = 1'b0;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  spi_xchg_seq #(.HALF_DIV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_len(tx_len), .tx_byte(tx_byte),
    .tx_next(tx_next), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .done(done), .err(err), .busy(busy)
  );

  int n_cmp = 0, n_bad = 0;
  int g_txl, g_pos, g_need, g_mode;
  logic [7:0] g_hdr;
  int tidx, ntn, nb, rxn, bp;
  logic [7:0] mbits;
  logic [7:0] mlog [64];
  logic [7:0] rlog [64];

  function automatic logic [7:0] obyte(int i);
    return 8'(8'h81 + i * 7);
  endfunction

  function automatic logic [7:0] devbyte(int k);
    int w;
    if (k < g_txl) return 8'hA5 ^ 8'(k);
    w = k - g_txl;
    if (g_mode == 1 && w < 4) return 8'h00;
    if (w < g_pos) return 8'h00;
    if (w == g_pos) return g_hdr;
    return 8'(8'h30 + (w - g_pos));
  endfunction

  function automatic logic devbit(int b);
    logic [7:0] v;
    v = devbyte(b / 8);
    return v[7 - (b % 8)];
  endfunction

  assign tx_byte = obyte(tidx);

  always @(negedge clk) begin
    if (tx_next) begin tidx++; ntn++; end
    if (rx_valid && rxn < 64) begin rlog[rxn] = rx_data; rxn++; end
  end

  always @(negedge cs_n) begin bp = 0; miso = devbit(0); end
  always @(negedge sclk) if (!cs_n) begin bp++; miso = devbit(bp); end
  always @(posedge sclk) if (!cs_n) begin
    mbits = {mbits[6:0], mosi};
    nb++;
    if (nb % 8 == 0 && nb / 8 <= 64) mlog[nb / 8 - 1] = mbits;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int txl, input int pos, input int need, input int mode, input bit poke);
    int exp_bytes, exp_rx, cyc;
    bit good;
    logic got_err;
    g_txl = txl; g_pos = pos; g_need = need; g_mode = mode;
    case (mode)
      2: g_hdr = {7'(need), ~^7'(need)};
      3: g_hdr = {7'd6, ^7'd6};
      default: g_hdr = {7'(need), ^7'(need)};
    endcase
    tidx = 0; ntn = 0; nb = 0; rxn = 0;
    if (mode == 0) begin
      exp_bytes = txl + 4 + (((need - (4 - pos)) > 0) ? need - (4 - pos) : 0);
      exp_rx = need;
    end else if (mode == 1) begin
      exp_bytes = txl + 4; exp_rx = 0;
    end else begin
      exp_bytes = txl + pos + 1; exp_rx = 0;
    end
    @(negedge clk); start = 1'b1; tx_len = 7'(txl);
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1'b1; tx_len = 7'd12;
      @(negedge clk); start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(cyc < 20000, "R8 watchdog", cyc, 20000);
    got_err = err;
    chk(cs_n == 1'b1, "R8 cs released at done", int'(cs_n), 1);
    @(negedge clk);
    chk(got_err == (mode != 0), mode == 1 ? "R6 err" : (mode >= 2 ? "R5 err" : "R7 err"),
        int'(got_err), int'(mode != 0));
    chk(nb == exp_bytes * 8, poke ? "R9 byte count" : "R7 byte count", nb, exp_bytes * 8);
    chk(ntn == txl, "R2 tx_next count", ntn, txl);
    good = 1'b1;
    for (int i = 0; i < exp_bytes && i < 64; i++)
      if (mlog[i] !== ((i < txl) ? obyte(i) : 8'h00)) good = 1'b0;
    chk(good, "R2/R3 mosi bytes", int'(good), 1);
    chk(rxn == exp_rx, "R4 reply count", rxn, exp_rx);
    good = 1'b1;
    for (int j = 0; j < rxn && j < 64; j++)
      if (rlog[j] !== ((j == 0) ? g_hdr : 8'(8'h30 + j))) good = 1'b0;
    chk(good, "R4 reply bytes", int'(good), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0 && rx_valid == 1'b0,
        "R1 reset state", int'({cs_n, sclk, busy, done, rx_valid}), 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", int'({cs_n, busy}), 2'b10);
    for (int t = 4; t <= 8; t += 4)
      for (int p = 0; p < 4; p++)
        for (int n = 4; n <= 12; n += 4)
          run(t, p, n, 0, 1'b0);
    run(4, 0, 4, 1, 1'b0);
    run(8, 0, 4, 1, 1'b0);
    for (int p = 0; p < 4; p++) run(4, p, 8, 2, 1'b0);
    run(4, 1, 8, 3, 1'b0);
    run(8, 3, 8, 3, 1'b0);
    run(8, 2, 12, 0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule